// File: doc/BRIEF.md
# Receive Holding Queue

This block sits between a byte deserializer and a register interface. It holds up to four received bytes in arrival order. It shows the oldest byte on its head output at all times, and it raises a ready flag when at least one byte is stored and a full flag when all four slots are taken. Ordinary bytes are admitted only when the receiver is enabled and the queue is not full. The block reports that condition on an accept output so that the deserializer can hold off.

A line-break event enters as a zero byte. It is always admitted, whatever the enable and the fill level. When the queue is already full, the break byte replaces the newest stored byte. The register side removes bytes with a pop strobe, and a pop on an empty queue does nothing. A flush input, driven by the receiver-reset command, discards everything in one cycle.

Top module: `rx_hold_fifo`

## Requirements
- R1: After reset the queue is empty: rx_rdy_o=0, ffull_o=0 and head_o=0x00.
- R2: The queue stores at most 4 bytes. ffull_o is 1 exactly when 4 are stored, and rx_rdy_o is 1 whenever at least 1 is stored.
- R3: An ordinary byte (byte_vld_i=1) is stored only when rx_en_i=1 and ffull_o=0 before that clock edge. can_accept_o equals rx_en_i AND NOT ffull_o. A rejected byte leaves contents and flags unchanged.
- R4: brk_i=1 stores the byte 0x00 regardless of rx_en_i and ffull_o. If byte_vld_i is also high in that cycle, the ordinary byte is dropped.
- R5: A break into a full queue, with no pop in that cycle, replaces the newest stored byte with 0x00. The count stays at 4 and the three older bytes keep their order.
- R6: head_o shows the oldest stored byte combinationally. pop_i removes it, so the next-oldest byte follows. After any pop ffull_o is 0, and rx_rdy_o falls when the last byte is removed.
- R7: With the queue empty, head_o is 0x00 and pop_i changes nothing. A push in the same cycle is still stored.
- R8: When a pop and a push fall in the same cycle, the pop is applied first and the push goes onto the reduced count. A full queue given a pop and a break in one cycle ends with 4 bytes, and the new 0x00 is the newest.
- R9: flush_i=1 empties the queue and clears rx_rdy_o and ffull_o at the next edge. It overrides any push or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable; gates ordinary bytes |
| byte_vld_i | input | 1 | Ordinary received byte is valid |
| byte_i | input | 8 | Ordinary received byte |
| brk_i | input | 1 | Break event; pushes a zero byte |
| pop_i | input | 1 | Remove the oldest byte |
| flush_i | input | 1 | Receiver reset; empty the queue |
| head_o | output | 8 | Oldest stored byte, 0x00 when empty |
| rx_rdy_o | output | 1 | At least one byte stored |
| ffull_o | output | 1 | All four slots stored |
| can_accept_o | output | 1 | An ordinary byte would be admitted |

## Verification
The bench goes after the full queue from several directions. An ordinary byte sent into a full queue must vanish, or the count would overflow. A break sent into a full queue must replace the newest byte, not the oldest, and must not be dropped. A pop and a break together on a full queue must end full, with the zero byte last; a design that applies the push before the pop would lose the zero byte or drop to three. It also checks a pop on an empty queue, which a wrong design lets underflow into a phantom full state, and a flush that arrives together with a push or a pop, which must leave nothing behind.

// File: rtl/rx_hold_pkg.sv
package rx_hold_pkg;
  parameter int unsigned RXH_DEPTH  = 4;
  parameter int unsigned RXH_DATA_W = 8;

  // kind of slot write performed at the next edge
  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,
    WR_APPEND  = 2'd1,
    WR_REPLACE = 2'd2
  } wr_mode_e;
endpackage

// File: rtl/rx_hold_admit.sv
module rx_hold_admit #(
  parameter int unsigned DATA_W = rx_hold_pkg::RXH_DATA_W
) (
  input  logic              rx_en_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              brk_i,
  input  logic              pop_i,
  input  logic              flush_i,
  input  logic              full_i,
  input  logic              empty_i,
  output logic              can_accept_o,
  output logic              push_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic              pop_o
);
  assign can_accept_o = rx_en_i & ~full_i;

  // break wins over an ordinary byte in the same cycle; flush kills both
  always_comb begin
    push_o      = 1'b0;
    push_data_o = '0;
    if (!flush_i) begin
      if (brk_i) begin
        push_o      = 1'b1;
        push_data_o = '0;
      end else if (byte_vld_i && can_accept_o) begin
        push_o      = 1'b1;
        push_data_o = byte_i;
      end
    end
  end

  assign pop_o = pop_i & ~flush_i & ~empty_i;
endmodule

// File: rtl/rx_hold_ctrl.sv
module rx_hold_ctrl
  import rx_hold_pkg::*;
#(
  parameter int unsigned DEPTH = RXH_DEPTH,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output wr_mode_e         wr_mode_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [PTR_W-1:0] rd_addr_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_d, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             append;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  // pop is taken first; only a push that still finds no room overwrites
  always_comb begin
    wr_mode_o = WR_NONE;
    if (push_i) wr_mode_o = (full_o && !pop_i) ? WR_REPLACE : WR_APPEND;
  end

  assign append    = (wr_mode_o == WR_APPEND);
  assign wr_addr_o = (wr_mode_o == WR_REPLACE) ? ptr_dec(wr_ptr_q) : wr_ptr_q;
  assign rd_addr_o = rd_ptr_q;

  always_comb begin
    rd_ptr_d = pop_i  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    wr_ptr_d = append ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    cnt_d    = cnt_q - CNT_W'(pop_i) + CNT_W'(append);
    if (flush_i) begin
      rd_ptr_d = '0;
      wr_ptr_d = '0;
      cnt_d    = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  assert_replace_keeps_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> (full_o && $stable(wr_ptr_q)));

  assert_pop_clears_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !flush_i) |=> (!full_o && (cnt_q == $past(cnt_q) - 1'b1)));

  assert_flush_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/rx_hold_store.sv
module rx_hold_store
  import rx_hold_pkg::*;
#(
  parameter int unsigned DEPTH  = RXH_DEPTH,
  parameter int unsigned DATA_W = RXH_DATA_W,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_mode_e          wr_mode_i,
  input  logic [PTR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic              wr_en;

  assign wr_en = (wr_mode_i != WR_NONE);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   slot_q[i] <= '0;
      else if (wr_en && (wr_addr_i == PTR_W'(i)))    slot_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_addr_i];
endmodule

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo
  import rx_hold_pkg::*;
#(
  parameter int unsigned DEPTH  = RXH_DEPTH,
  parameter int unsigned DATA_W = RXH_DATA_W,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              brk_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic [DATA_W-1:0] head_o,
  output logic              rx_rdy_o,
  output logic              ffull_o,
  output logic              can_accept_o
);
  logic              push, pop_eff, full, empty;
  logic [DATA_W-1:0] push_data, rd_data;
  logic [PTR_W-1:0]  wr_addr, rd_addr;
  wr_mode_e          wr_mode;

  rx_hold_admit #(.DATA_W(DATA_W)) u_admit (
    .rx_en_i     (rx_en_i),
    .byte_vld_i  (byte_vld_i),
    .byte_i      (byte_i),
    .brk_i       (brk_i),
    .pop_i       (pop_i),
    .flush_i     (flush_i),
    .full_i      (full),
    .empty_i     (empty),
    .can_accept_o(can_accept_o),
    .push_o      (push),
    .push_data_o (push_data),
    .pop_o       (pop_eff)
  );

  rx_hold_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push),
    .pop_i    (pop_eff),
    .flush_i  (flush_i),
    .wr_mode_o(wr_mode),
    .wr_addr_o(wr_addr),
    .rd_addr_o(rd_addr),
    .full_o   (full),
    .empty_o  (empty)
  );

  rx_hold_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_mode_i(wr_mode),
    .wr_addr_i(wr_addr),
    .wr_data_i(push_data),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  assign head_o   = empty ? '0 : rd_data;
  assign rx_rdy_o = ~empty;
  assign ffull_o  = full;

  assert_reject_no_effect_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !can_accept_o && !brk_i && !pop_i && !flush_i)
      |=> ($stable(head_o) && (ffull_o == $past(ffull_o)) && (rx_rdy_o == $past(rx_rdy_o))));

  assert_brk_lands_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_i && !flush_i) |=> rx_rdy_o);

  assert_empty_pop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_rdy_o && pop_i && !brk_i && !byte_vld_i && !flush_i) |=> (!rx_rdy_o && !ffull_o));
endmodule

// File: tb/tb_rx_hold_fifo.sv
`timescale 1ns/1ps
module tb_rx_hold_fifo;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_en_i = 1'b0, byte_vld_i = 1'b0, brk_i = 1'b0, pop_i = 1'b0, flush_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic [7:0] head_o;
  logic       rx_rdy_o, ffull_o, can_accept_o;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  byte unsigned exp_q[$];

  always #2.5 clk_i = ~clk_i;

  rx_hold_fifo dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .brk_i(brk_i), .pop_i(pop_i), .flush_i(flush_i),
    .head_o(head_o), .rx_rdy_o(rx_rdy_o), .ffull_o(ffull_o), .can_accept_o(can_accept_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_state(string tag);
    int n = exp_q.size();
    chk(tag, "rx_rdy_o", rx_rdy_o, (n > 0));
    chk(tag, "ffull_o", ffull_o, (n == 4));
    chk(tag, "can_accept_o", can_accept_o, (rx_en_i && n < 4));
    chk(tag, "head_o", head_o, (n > 0) ? exp_q[0] : 8'h00);
  endtask

  // driver: one operation, model update from the requirements, then monitor check
  task automatic cyc(string tag, bit en, bit vld, byte unsigned d, bit brk, bit pop, bit fl);
    bit  was_full;
    bit  p;
    byte unsigned v;
    @(negedge clk_i);
    rx_en_i = en; byte_vld_i = vld; byte_i = d; brk_i = brk; pop_i = pop; flush_i = fl;
    #1;
    if (pop && !fl) chk(tag, "popped byte", head_o, (exp_q.size() > 0) ? exp_q[0] : 8'h00);
    was_full = (exp_q.size() == 4);
    if (fl) exp_q.delete();
    else begin
      if (pop && exp_q.size() > 0) void'(exp_q.pop_front());
      p = brk || (vld && en && !was_full);
      v = brk ? 8'h00 : d;
      if (p) begin
        if (exp_q.size() == 4) exp_q[3] = v;
        else exp_q.push_back(v);
      end
    end
    @(posedge clk_i);
    #1;
    byte_vld_i = 1'b0; brk_i = 1'b0; pop_i = 1'b0; flush_i = 1'b0;
    @(negedge clk_i);
    chk_state(tag);
  endtask

  initial begin
    #500us;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_state("R1");

    // R3: disabled receiver drops ordinary bytes
    cyc("R3", 0, 1, 8'hA5, 0, 0, 0);
    // R2: fill to four
    cyc("R2", 1, 1, 8'h11, 0, 0, 0);
    cyc("R2", 1, 1, 8'h22, 0, 0, 0);
    cyc("R2", 1, 1, 8'h33, 0, 0, 0);
    cyc("R2", 1, 1, 8'h44, 0, 0, 0);
    // R3: full queue rejects ordinary byte
    cyc("R3", 1, 1, 8'h55, 0, 0, 0);
    // R5: break into full replaces newest
    cyc("R5", 1, 0, 8'h00, 1, 0, 0);
    // R6: drain in order 11 22 33 00
    for (int i = 0; i < 4; i++) cyc("R6", 1, 0, 8'h00, 0, 1, 0);
    // R7: pop on empty, then pop with push
    cyc("R7", 1, 0, 8'h00, 0, 1, 0);
    cyc("R7", 1, 1, 8'h66, 0, 1, 0);
    cyc("R6", 1, 0, 8'h00, 0, 1, 0);
    // R4: break while disabled, break with ordinary byte
    cyc("R4", 0, 0, 8'h00, 1, 0, 0);
    cyc("R4", 1, 1, 8'h77, 1, 0, 0);
    cyc("R4", 1, 1, 8'h78, 0, 0, 0);
    cyc("R4", 1, 1, 8'h79, 0, 0, 0);
    // R8: full, pop + break, then pop + ordinary byte (rejected: was full)
    cyc("R8", 1, 0, 8'h00, 1, 1, 0);
    cyc("R8", 1, 1, 8'h9A, 0, 1, 0);
    cyc("R8", 1, 1, 8'h9B, 0, 1, 0);
    // R9: flush with push and pop pending
    cyc("R9", 1, 1, 8'hBC, 1, 1, 1);
    cyc("R9", 1, 1, 8'hC1, 0, 0, 0);
    cyc("R9", 1, 0, 8'h00, 0, 0, 1);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      cyc("R8", r[0] | r[1], r[2], r[15:8], (r[6:3] == 4'h0), r[7] & r[16], (r[21:17] == 5'h0));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule